// File: doc/BRIEF.md
# Floating-point and debug state register file

This block holds the architectural state that sits beside a floating-point unit: control word, status word, tag word, last opcode, the vector control/status word, the instruction and operand pointer registers, and a three-bit stack-top index. It also holds a bank of debug registers: four breakpoint addresses, a debug status word and a debug control word. A single indexed port reads and writes these registers. Every write is trimmed to the width the register has in the architecture. The pointer registers are trimmed only when the `longSub` sideband input shows that the core is outside 64-bit submode.

The stack-top index is kept in its own register. A status-word write also loads status bits 13:11 into that register. A status-word read shows the stored word with bits 13:11 replaced by the current stack-top value. In the debug bank, offsets 4 and 5 redirect to the status and control words. Each of those two words has a fixed set of bits that software may change, and every other bit keeps its value. Any breakpoint enable left set in the control word raises `bpError`, because this block does not match breakpoints.

Reads are registered and return one cycle after the request. A read of an unused index returns zero and flags it as illegal. A write to an unused index is dropped.

Top module: `fpdbg_state_rf`

## Requirements
- R1: After reset, every floating-point register and the stack-top index read zero, breakpoint addresses 0 to 3 read zero, debug status (address 0x16) reads 0xFFFF0FF0, debug control (address 0x17) reads 0x400, and `bpError` is 0.
- R2: In the floating-point bank (address bit 4 = 0), writes are trimmed to these widths: control word (0x00) 16 bits, tag word (0x02) 8 bits, last opcode (0x03) 16 bits, vector control/status (0x04) 32 bits, stack-top index (0x09) 3 bits. The upper bits read as zero.
- R3: A write to the status word (0x01) stores the low 16 bits of the data. The same write loads data bits 13:11 into the stack-top index, which can then be read at 0x09.
- R4: A read of the status word returns the stored word with bits 13:11 replaced by the current stack-top index. A later direct write to 0x09 therefore changes what 0x01 returns.
- R5: When `longSub` = 0 during a write, the pointer segment registers (0x05, 0x07) are trimmed to 16 bits and the pointer offset registers (0x06, 0x08) to 32 bits. When `longSub` = 1, the full data word is stored.
- R6: In the debug bank (address bit 4 = 1), offset 4 (0x14) reaches the debug status word and offset 5 (0x15) reaches the debug control word, for both reads and writes.
- R7: A debug status write changes only bits 0 to 3, 13, 14 and 15 (mask 0xE00F). All other bits, including bits 63:32, keep their values.
- R8: A debug control write changes only bits 7:0 (the local and global enables), bit 13 and bits 31:16 (mask 0xFFFF20FF). All other bits keep their values. `bpError` is 1 exactly while any of bits 7:0 is set.
- R9: Addresses 0x0A to 0x0F and 0x18 to 0x1F are illegal. Reads of them return data 0 with `rdIllegal` = 1, and writes to them change no register.
- R10: The result of a read appears on `rdData` with `rdValid` = 1 in the cycle after `rdEn`. A read issued in the same cycle as a write to the same register returns the value from before the write.
- R11: Breakpoint addresses 0 to 3 (0x10 to 0x13) store the full data word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write request for `addr` |
| rdEn | input | 1 | Read request for `addr` |
| addr | input | 5 | Register index; bit 4 selects the debug bank |
| wrData | input | DATA_W | Write data |
| longSub | input | 1 | Core is in 64-bit submode; controls how the pointer registers are trimmed |
| rdData | output | DATA_W | Registered read data |
| rdValid | output | 1 | `rdData` holds the result of the previous cycle's read |
| rdIllegal | output | 1 | The previous read targeted an unused index |
| bpError | output | 1 | A breakpoint enable is set in debug control |

## Verification
A read and a write can target the same register in the same cycle. The bench drives `rdEn` and `wrEn` together on the control word and expects the value from before the write. A plain read in the next cycle must then return the new value. The status word and the stack-top index also meet in one cycle: one status write updates both, so the bench first reads each one alone and then checks their merged view after a later direct write to the stack-top index.

// File: rtl/fpdbg_pkg.sv
package fpdbg_pkg;

  localparam int ADDR_W = 5;

  typedef enum logic [3:0] {
    ID_CW    = 4'd0,
    ID_SW    = 4'd1,
    ID_TW    = 4'd2,
    ID_FOP   = 4'd3,
    ID_VCSR  = 4'd4,
    ID_ISEG  = 4'd5,
    ID_IOFF  = 4'd6,
    ID_OSEG  = 4'd7,
    ID_OOFF  = 4'd8,
    ID_TOP   = 4'd9,
    ID_BP0   = 4'd10,
    ID_BP1   = 4'd11,
    ID_BP2   = 4'd12,
    ID_BP3   = 4'd13,
    ID_DSTAT = 4'd14,
    ID_DCTRL = 4'd15
  } regId_e;

  localparam int NUM_REGS = 16;

  typedef struct packed {
    logic   we;
    regId_e wrId;
    logic   topLoad;
    logic   rd;
    regId_e rdId;
    logic   rdBad;
  } rfStrobe_t;

  typedef struct packed {
    logic   ok;
    regId_e id;
  } decode_t;

endpackage

// File: rtl/fpdbg_ctrl.sv
module fpdbg_ctrl
  import fpdbg_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  output rfStrobe_t         strobe
);

  localparam int FPU_LAST = 9;
  localparam int DBG_SPAN = 8;

  function automatic decode_t decodeAddr(input logic [ADDR_W-1:0] a);
    decode_t    d;
    logic [3:0] off;
    off  = a[3:0];
    d.ok = 1'b0;
    d.id = ID_CW;
    if (!a[ADDR_W-1]) begin
      if (int'(off) <= FPU_LAST) begin
        d.ok = 1'b1;
        d.id = regId_e'(off);
      end
    end else if (int'(off) < DBG_SPAN) begin
      d.ok = 1'b1;
      if (!off[2]) d.id = regId_e'(4'd10 + {2'b00, off[1:0]});
      else if (!off[0]) d.id = ID_DSTAT;
      else d.id = ID_DCTRL;
    end
    return d;
  endfunction

  decode_t dec;

  always_comb begin
    dec            = decodeAddr(addr);
    strobe.we      = wrEn && dec.ok;
    strobe.wrId    = dec.id;
    strobe.topLoad = wrEn && dec.ok && (dec.id == ID_SW);
    strobe.rd      = rdEn;
    strobe.rdId    = dec.id;
    strobe.rdBad   = !dec.ok;
  end

  // R6: debug offsets 4 and 5 must land on the status and control words
  assert_alias_stat_R6: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == 5'h14) |-> (strobe.we && strobe.wrId == ID_DSTAT));
  assert_alias_ctrl_R6: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == 5'h15) |-> (strobe.we && strobe.wrId == ID_DCTRL));

endmodule

// File: rtl/fpdbg_datapath.sv
module fpdbg_datapath
  import fpdbg_pkg::*;
#(
  parameter int DATA_W = 64
)(
  input  logic              clk,
  input  logic              rstN,
  input  rfStrobe_t         strobe,
  input  logic [DATA_W-1:0] wrData,
  input  logic              longSub,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid,
  output logic              rdIllegal,
  output logic              bpError
);

  localparam int TOP_W   = 3;
  localparam int TOP_LSB = 11;
  localparam int HALF_W  = 16;
  localparam int BYTE_W  = 8;
  localparam int WORD_W  = 32;
  localparam int EN_W    = 8;
  localparam logic [DATA_W-1:0] DSTAT_MASK  = DATA_W'(32'h0000_E00F);
  localparam logic [DATA_W-1:0] DCTRL_MASK  = DATA_W'(32'hFFFF_20FF);
  localparam logic [DATA_W-1:0] DSTAT_RESET = DATA_W'(32'hFFFF_0FF0);
  localparam logic [DATA_W-1:0] DCTRL_RESET = DATA_W'(32'h0000_0400);

  function automatic logic [DATA_W-1:0] lowOnes(input int n);
    logic [DATA_W-1:0] all;
    all = '1;
    if (n >= DATA_W) return all;
    return all >> (DATA_W - n);
  endfunction

  function automatic logic [DATA_W-1:0] resetVal(input int idx);
    if (idx == int'(ID_DSTAT)) return DSTAT_RESET;
    if (idx == int'(ID_DCTRL)) return DCTRL_RESET;
    return '0;
  endfunction

  logic [DATA_W-1:0] regs [NUM_REGS];
  logic [DATA_W-1:0] wrMask;
  logic              wrMerge;
  logic [DATA_W-1:0] nextVal;
  logic [DATA_W-1:0] swView;

  // width and merge rule for the addressed register
  always_comb begin
    wrMerge = 1'b0;
    unique case (strobe.wrId)
      ID_CW, ID_SW, ID_FOP: wrMask = lowOnes(HALF_W);
      ID_TW:                wrMask = lowOnes(BYTE_W);
      ID_VCSR:              wrMask = lowOnes(WORD_W);
      ID_TOP:               wrMask = lowOnes(TOP_W);
      ID_ISEG, ID_OSEG:     wrMask = longSub ? lowOnes(DATA_W) : lowOnes(HALF_W);
      ID_IOFF, ID_OOFF:     wrMask = longSub ? lowOnes(DATA_W) : lowOnes(WORD_W);
      ID_DSTAT: begin
        wrMask  = DSTAT_MASK;
        wrMerge = 1'b1;
      end
      ID_DCTRL: begin
        wrMask  = DCTRL_MASK;
        wrMerge = 1'b1;
      end
      default:              wrMask = lowOnes(DATA_W);
    endcase
    if (wrMerge) nextVal = (regs[strobe.wrId] & ~wrMask) | (wrData & wrMask);
    else         nextVal = wrData & wrMask;
  end

  genvar gi;
  generate
    for (gi = 0; gi < NUM_REGS; gi++) begin : g_reg
      if (gi == int'(ID_TOP)) begin : g_top
        always_ff @(posedge clk) begin
          if (!rstN) regs[gi] <= resetVal(gi);
          else if (strobe.we && strobe.wrId == regId_e'(gi)) regs[gi] <= nextVal;
          else if (strobe.topLoad)
            regs[gi] <= DATA_W'(wrData[TOP_LSB +: TOP_W]);
        end
      end else begin : g_plain
        always_ff @(posedge clk) begin
          if (!rstN) regs[gi] <= resetVal(gi);
          else if (strobe.we && strobe.wrId == regId_e'(gi)) regs[gi] <= nextVal;
        end
      end
    end
  endgenerate

  // status word as seen by a reader: stack-top field substituted
  always_comb begin
    swView = regs[ID_SW];
    swView[TOP_LSB +: TOP_W] = regs[ID_TOP][TOP_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData    <= '0;
      rdValid   <= 1'b0;
      rdIllegal <= 1'b0;
    end else begin
      rdValid   <= strobe.rd;
      rdIllegal <= strobe.rd && strobe.rdBad;
      if (strobe.rd) begin
        if (strobe.rdBad)              rdData <= '0;
        else if (strobe.rdId == ID_SW) rdData <= swView;
        else                           rdData <= regs[strobe.rdId];
      end
    end
  end

  assign bpError = |regs[ID_DCTRL][EN_W-1:0];

  // R7: bits outside the writable set survive a debug status write
  assert_dstat_keep_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.we && strobe.wrId == ID_DSTAT) |=>
      ((regs[ID_DSTAT] & ~DSTAT_MASK) == $past(regs[ID_DSTAT] & ~DSTAT_MASK)));

  // R3: a status write leaves bits 13:11 of the data in the stack-top index
  assert_top_load_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.topLoad |=> (regs[ID_TOP][TOP_W-1:0] == $past(wrData[TOP_LSB +: TOP_W])));

  // R9: an illegal read never returns data
  assert_illegal_zero_R9: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && rdIllegal) |-> (rdData == '0));

  // R8: the error only appears after a write to debug control
  assert_bp_rise_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(bpError) |-> $past(strobe.we && strobe.wrId == ID_DCTRL));

endmodule

// File: rtl/fpdbg_state_rf.sv
module fpdbg_state_rf
  import fpdbg_pkg::*;
#(
  parameter int DATA_W = 64
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              longSub,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid,
  output logic              rdIllegal,
  output logic              bpError
);

  rfStrobe_t strobe;

  fpdbg_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .rdEn   (rdEn),
    .addr   (addr),
    .strobe (strobe)
  );

  fpdbg_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .wrData    (wrData),
    .longSub   (longSub),
    .rdData    (rdData),
    .rdValid   (rdValid),
    .rdIllegal (rdIllegal),
    .bpError   (bpError)
  );

  // R10: every read request yields a result one cycle later
  assert_rd_latency_R10: assert property (@(posedge clk) disable iff (!rstN)
    rdEn |=> rdValid);

endmodule

// File: tb/fpdbg_state_rf_tb.sv
`timescale 1ns/1ps
module fpdbg_state_rf_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [4:0]  addr = '0;
  logic [63:0] wrData = '0;
  logic        longSub = 1'b0;
  logic [63:0] rdData;
  logic        rdValid;
  logic        rdIllegal;
  logic        bpError;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic [63:0] data;
    logic        bad;
    string       tag;
  } exp_t;
  exp_t sbq[$];

  always #4 clk = ~clk;

  fpdbg_state_rf u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .longSub(longSub), .rdData(rdData),
    .rdValid(rdValid), .rdIllegal(rdIllegal), .bpError(bpError)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: compare each read result with the oldest expectation
  always @(negedge clk) begin
    if (rstN && rdValid) begin
      if (sbq.size() == 0) begin
        checks++;
        errors++;
        $display("FAIL R10 unexpected result actual=%h expected=none", rdData);
      end else begin
        exp_t e;
        e = sbq.pop_front();
        chk(rdData == e.data && rdIllegal == e.bad, e.tag,
            {rdData[62:0], rdIllegal}, {e.data[62:0], e.bad});
        if (rdData != e.data) $display("  data actual=%h expected=%h", rdData, e.data);
      end
    end
  end

  task automatic rd(input logic [4:0] a, input logic [63:0] e, input logic bad, input string tag);
    @(negedge clk);
    addr = a; rdEn = 1'b1; wrEn = 1'b0;
    sbq.push_back('{e, bad, tag});
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic wr(input logic [4:0] a, input logic [63:0] d, input logic ls);
    @(negedge clk);
    addr = a; wrData = d; longSub = ls; wrEn = 1'b1; rdEn = 1'b0;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rdwr(input logic [4:0] a, input logic [63:0] d, input logic [63:0] e, input string tag);
    @(negedge clk);
    addr = a; wrData = d; longSub = 1'b0; wrEn = 1'b1; rdEn = 1'b1;
    sbq.push_back('{e, 1'b0, tag});
    @(negedge clk);
    wrEn = 1'b0; rdEn = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(bpError == 1'b0, "R1 bpError after reset", 64'(bpError), 64'd0);
    for (int i = 0; i < 10; i++) rd(5'(i), 64'd0, 1'b0, "R1 fpu reset");
    for (int i = 0; i < 4; i++) rd(5'(16 + i), 64'd0, 1'b0, "R1 bp reset");
    rd(5'h16, 64'hFFFF_0FF0, 1'b0, "R1 dstat reset");
    rd(5'h17, 64'h0000_0400, 1'b0, "R1 dctrl reset");

    wr(5'h00, 64'hDEAD_BEEF_1234_5678, 1'b0);
    rd(5'h00, 64'h5678, 1'b0, "R2 control word 16b");
    wr(5'h02, 64'hFFFF, 1'b0);
    rd(5'h02, 64'hFF, 1'b0, "R2 tag word 8b");
    wr(5'h03, 64'hABCDE, 1'b0);
    rd(5'h03, 64'hBCDE, 1'b0, "R2 opcode 16b");
    wr(5'h04, 64'h1122_3344_5566_7788, 1'b0);
    rd(5'h04, 64'h5566_7788, 1'b0, "R2 vector csr 32b");
    wr(5'h09, 64'hF, 1'b0);
    rd(5'h09, 64'h7, 1'b0, "R2 top 3b");

    wr(5'h01, 64'hFFFF_FFFF_FFFF_C7FF, 1'b0);
    rd(5'h09, 64'h0, 1'b0, "R3 top from status write");
    rd(5'h01, 64'hC7FF, 1'b0, "R3 status stored 16b");
    wr(5'h09, 64'h5, 1'b0);
    rd(5'h01, 64'hEFFF, 1'b0, "R4 status merges top");
    wr(5'h01, 64'h3800, 1'b0);
    rd(5'h09, 64'h7, 1'b0, "R3 top loaded 7");
    wr(5'h09, 64'h2, 1'b0);
    rd(5'h01, 64'h1000, 1'b0, "R4 status merges new top");

    wr(5'h05, 64'hAAAA_BBBB_CCCC_DDDD, 1'b0);
    rd(5'h05, 64'hDDDD, 1'b0, "R5 seg 16b legacy");
    wr(5'h06, 64'hAAAA_BBBB_CCCC_DDDD, 1'b0);
    rd(5'h06, 64'hCCCC_DDDD, 1'b0, "R5 off 32b legacy");
    wr(5'h07, 64'hAAAA_BBBB_CCCC_DDDD, 1'b1);
    rd(5'h07, 64'hAAAA_BBBB_CCCC_DDDD, 1'b0, "R5 seg full in 64b");
    wr(5'h08, 64'h1111_2222_3333_4444, 1'b1);
    rd(5'h08, 64'h1111_2222_3333_4444, 1'b0, "R5 off full in 64b");

    wr(5'h10, 64'h0123_4567_89AB_CDEF, 1'b0);
    rd(5'h10, 64'h0123_4567_89AB_CDEF, 1'b0, "R11 bp0 full");
    wr(5'h13, 64'hFEDC_BA98_7654_3210, 1'b0);
    rd(5'h13, 64'hFEDC_BA98_7654_3210, 1'b0, "R11 bp3 full");

    wr(5'h16, '1, 1'b0);
    rd(5'h16, 64'h0000_0000_FFFF_EFFF, 1'b0, "R7 dstat set writable");
    wr(5'h14, 64'd0, 1'b0);
    rd(5'h16, 64'hFFFF_0FF0, 1'b0, "R6 alias 4 writes dstat");
    rd(5'h14, 64'hFFFF_0FF0, 1'b0, "R6 alias 4 reads dstat");

    wr(5'h15, '1, 1'b0);
    chk(bpError == 1'b1, "R8 bpError set", 64'(bpError), 64'd1);
    rd(5'h17, 64'hFFFF_24FF, 1'b0, "R6 alias 5 writes dctrl");
    wr(5'h17, 64'h0000_0000_5555_2000, 1'b0);
    chk(bpError == 1'b0, "R8 bpError clear", 64'(bpError), 64'd0);
    rd(5'h17, 64'h5555_2400, 1'b0, "R8 dctrl partial");
    wr(5'h17, 64'h0000_0000_5555_2080, 1'b0);
    chk(bpError == 1'b1, "R8 bpError on G3", 64'(bpError), 64'd1);
    rd(5'h15, 64'h5555_2480, 1'b0, "R6 alias 5 reads dctrl");

    rd(5'h0C, 64'd0, 1'b1, "R9 illegal read fpu bank");
    rd(5'h1F, 64'd0, 1'b1, "R9 illegal read dbg bank");
    wr(5'h19, 64'hBAD0_BAD0_BAD0_BAD0, 1'b0);
    rd(5'h11, 64'd0, 1'b0, "R9 illegal write ignored bp1");
    wr(5'h0A, 64'hFFFF_FFFF, 1'b0);
    rd(5'h02, 64'hFF, 1'b0, "R9 illegal write ignored tw");
    rd(5'h00, 64'h5678, 1'b0, "R9 illegal write ignored cw");

    rdwr(5'h00, 64'h1111, 64'h5678, "R10 read during write old");
    rd(5'h00, 64'h1111, 1'b0, "R10 new value after write");

    repeat (4) @(negedge clk);
    chk(sbq.size() == 0, "R10 all reads returned", 64'(sbq.size()), 64'd0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R10 watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule